// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block sequences the power and clock policy of a small microcontroller-style system. Software chooses a working RUN sub-mode, or asks to enter a low-power family (SLEEP, STOP, STANDBY or SHUTDOWN) with a sub-policy. From the resulting mode the block drives these outputs:
- the high-speed oscillator enable;
- the gates and frequency selects of the CPU, main and ultra-low-power clock trees;
- the gate of the timer/RTC clock;
- the regulator drive level;
- a power-off indication.

Wake events come in on three inputs, one per class: any interrupt, an always-on-domain interrupt, and IO/reset-pin/debug. Each family listens only to its own class. A wake returns the system to the RUN sub-mode it left. When that sub-mode needs the oscillator and the oscillator is off, the block first turns it on and waits for its ready input. A wake from SHUTDOWN does not resume. It pulses a full-reset output and restarts in RUN0.

All policy outputs are registered and change on the same clock edge as the mode, so a mode change produces no glitch.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode is RUN0. `mode_o` uses these codes: RUN0..2 = 0..2, SLEEP0..2 = 3..5, STOP0..2 = 6..8, STANDBY0/1 = 9/10, SHUTDOWN = 11. In RUN0 the oscillator is on, the CPU and main clocks run fast, `ulp_clk_sel` is 2 (32 MHz), and `osc_busy` and `sys_reset_out` are low.
- R2: A request with family 0 (RUN) and sub 0..2 selects the RUN sub-mode. RUN1 keeps the oscillator on with the main clock slow and `ulp_clk_sel` 0 (32 kHz). RUN2 turns the oscillator off and keeps the same slow clocks.
- R3: Family 1 (SLEEP) ignores the sub field. It enters SLEEPx, where x is the current RUN sub-mode. The CPU clock is gated and the main clock and oscillator keep their RUNx settings.
- R4: Family 2 with sub 0 enters STOP0 and gates the CPU and main clocks. Entered from RUN0 it gives `ulp_clk_sel` 1 (4 MHz). Entered from RUN1 it keeps the oscillator on and `ulp_clk_sel` 0. Entered from RUN2 it keeps the oscillator off and `ulp_clk_sel` 0.
- R5: STOP1 (sub 1) sets `ulp_clk_sel` to 1 with the oscillator on. STOP2 (sub 2) sets `ulp_clk_sel` to 0 with the oscillator off.
- R6: Family 3 enters STANDBY0 (sub 0) or STANDBY1 (sub 1). Both gate the CPU and main clocks, turn the oscillator off and keep `timer_clk_en` on. STANDBY0 keeps `ulp_clk_en` at 32 kHz and STANDBY1 gates it.
- R7: `vreg_drive` is 3 in RUN/SLEEP, 2 in STOP, 1 in STANDBY and 0 in SHUTDOWN (family 4). SHUTDOWN drops every enable and raises `retain_off`.
- R8: SLEEP wakes on `wake_irq_any` or `wake_irq_aon`. STOP and STANDBY wake only on `wake_irq_aon`. SHUTDOWN wakes only on `wake_io`. Any other wake input leaves the mode unchanged.
- R9: A wake from SHUTDOWN raises `sys_reset_out` for exactly one cycle and restarts in RUN0 with the RUN sub-mode cleared.
- R10: A wake returns to the RUN sub-mode active before entry. If that sub-mode needs the oscillator and it was off, `osc_en` and `osc_busy` rise and the mode holds until `osc_ready` is seen. The same wait applies to a RUN0/RUN1 request made from RUN2.
- R11: These requests are ignored and the mode is unchanged: any entry request while `osc_busy` is high, an entry request while in a low-power family, and a request with an unsupported sub code (STOP sub 3, STANDBY sub 2 or 3, RUN sub 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_req | input | 1 | Mode request strobe |
| entry_family | input | 3 | 0 RUN, 1 SLEEP, 2 STOP, 3 STANDBY, 4 SHUTDOWN |
| entry_sub | input | 2 | Sub-policy within the family |
| wake_irq_any | input | 1 | Any interrupt pending |
| wake_irq_aon | input | 1 | Always-on-domain interrupt pending |
| wake_io | input | 1 | IO wake, reset pin or debug request |
| osc_ready | input | 1 | High-speed oscillator is stable |
| osc_en | output | 1 | High-speed oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate |
| main_clk_en | output | 1 | Main clock gate |
| main_clk_fast | output | 1 | Main clock source: 1 = 32 MHz, 0 = 32 kHz |
| ulp_clk_en | output | 1 | Ultra-low-power bus clock gate |
| ulp_clk_sel | output | 2 | 0 = 32 kHz, 1 = 4 MHz, 2 = 32 MHz |
| timer_clk_en | output | 1 | Timer/RTC 32 kHz clock gate |
| vreg_drive | output | 2 | Regulator drive: 3 full, 2 reduced, 1 low, 0 off |
| retain_off | output | 1 | Domain powered off, state lost |
| sys_reset_out | output | 1 | Full-reset pulse after SHUTDOWN wake |
| mode_o | output | 4 | Current mode code |
| osc_busy | output | 1 | Oscillator-ready handshake pending |

## Verification
The main function is driven by one table of mode walks.
- STOP0 is entered from each of the three RUN sub-modes. This separates the entry-dependent oscillator and ultra-low-power clock results from a fixed STOP0 mapping.
- Each family is hit with every wake class. This shows whether the design filters wake sources per family rather than waking on any input.
- Round trips through SLEEP, STOP and STANDBY from RUN0, RUN1 and RUN2 show whether the prior sub-mode is restored.
- Directed tests hold `osc_ready` low. They check that the handshake stalls the mode and that a request made during the stall is dropped.
- A directed test wakes from SHUTDOWN and checks that the reset pulse lasts exactly one cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int MODE_W = 4;
  localparam int SUB_W  = 2;
  localparam int FAM_W  = 3;
  localparam int DRV_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    M_RUN0 = 4'd0,  M_RUN1 = 4'd1,  M_RUN2 = 4'd2,
    M_SLP0 = 4'd3,  M_SLP1 = 4'd4,  M_SLP2 = 4'd5,
    M_STP0 = 4'd6,  M_STP1 = 4'd7,  M_STP2 = 4'd8,
    M_SBY0 = 4'd9,  M_SBY1 = 4'd10, M_SHDN = 4'd11
  } mode_t;

  localparam logic [FAM_W-1:0] FAM_RUN  = 3'd0;
  localparam logic [FAM_W-1:0] FAM_SLP  = 3'd1;
  localparam logic [FAM_W-1:0] FAM_STP  = 3'd2;
  localparam logic [FAM_W-1:0] FAM_SBY  = 3'd3;
  localparam logic [FAM_W-1:0] FAM_SHDN = 3'd4;

  localparam logic [1:0] SEL_32K = 2'd0;
  localparam logic [1:0] SEL_4M  = 2'd1;
  localparam logic [1:0] SEL_32M = 2'd2;

  localparam logic [DRV_W-1:0] DRV_OFF  = 2'd0;
  localparam logic [DRV_W-1:0] DRV_LOW  = 2'd1;
  localparam logic [DRV_W-1:0] DRV_RED  = 2'd2;
  localparam logic [DRV_W-1:0] DRV_FULL = 2'd3;

  typedef struct packed {
    logic             osc;
    logic             cpu;
    logic             mclk;
    logic             fast;
    logic             ulp_en;
    logic [1:0]       ulp_sel;
    logic             tim;
    logic [DRV_W-1:0] drive;
    logic             off;
  } pol_t;

  function automatic logic is_run(mode_t m);
    return (m == M_RUN0) || (m == M_RUN1) || (m == M_RUN2);
  endfunction

  function automatic mode_t run_mode(logic [SUB_W-1:0] s);
    return mode_t'({2'b00, s});
  endfunction

  // Policy of one mode; rs is the RUN sub-mode the mode was entered from.
  function automatic pol_t policy_of(mode_t m, logic [SUB_W-1:0] rs);
    pol_t p;
    p = '0;
    case (m)
      M_RUN0, M_SLP0: begin
        p.osc = 1'b1; p.mclk = 1'b1; p.fast = 1'b1;
        p.ulp_en = 1'b1; p.ulp_sel = SEL_32M; p.tim = 1'b1; p.drive = DRV_FULL;
      end
      M_RUN1, M_SLP1: begin
        p.osc = 1'b1; p.mclk = 1'b1;
        p.ulp_en = 1'b1; p.ulp_sel = SEL_32K; p.tim = 1'b1; p.drive = DRV_FULL;
      end
      M_RUN2, M_SLP2: begin
        p.mclk = 1'b1;
        p.ulp_en = 1'b1; p.ulp_sel = SEL_32K; p.tim = 1'b1; p.drive = DRV_FULL;
      end
      M_STP0: begin
        p.osc = (rs != 2'd2);
        p.ulp_sel = (rs == 2'd0) ? SEL_4M : SEL_32K;
        p.ulp_en = 1'b1; p.tim = 1'b1; p.drive = DRV_RED;
      end
      M_STP1: begin
        p.osc = 1'b1; p.ulp_en = 1'b1; p.ulp_sel = SEL_4M;
        p.tim = 1'b1; p.drive = DRV_RED;
      end
      M_STP2: begin
        p.ulp_en = 1'b1; p.ulp_sel = SEL_32K; p.tim = 1'b1; p.drive = DRV_RED;
      end
      M_SBY0: begin
        p.ulp_en = 1'b1; p.ulp_sel = SEL_32K; p.tim = 1'b1; p.drive = DRV_LOW;
      end
      M_SBY1: begin
        p.tim = 1'b1; p.drive = DRV_LOW;
      end
      default: begin
        p.off = 1'b1; p.drive = DRV_OFF;
      end
    endcase
    if (is_run(m)) p.cpu = 1'b1;
    return p;
  endfunction

endpackage

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_req,
  input  logic [FAM_W-1:0] entry_family,
  input  logic [SUB_W-1:0] entry_sub,
  input  logic             wake_irq_any,
  input  logic             wake_irq_aon,
  input  logic             wake_io,
  input  logic             osc_ready,
  output mode_t            mode_d,
  output logic [SUB_W-1:0] run_d,
  output logic             pend_d,
  output mode_t            mode_q,
  output logic             pend_q,
  output logic             rst_q
);

  logic [SUB_W-1:0] run_q, tgt_q, tgt_d, tgt_w;
  logic             rst_d, wake_ok, is_slp, is_stb;
  pol_t             cur_pol;

  always_comb begin
    is_slp  = (mode_q == M_SLP0) || (mode_q == M_SLP1) || (mode_q == M_SLP2);
    is_stb  = (mode_q == M_STP0) || (mode_q == M_STP1) || (mode_q == M_STP2) ||
              (mode_q == M_SBY0) || (mode_q == M_SBY1);
    wake_ok = (is_slp && (wake_irq_any || wake_irq_aon)) ||
              (is_stb && wake_irq_aon) ||
              ((mode_q == M_SHDN) && wake_io);
    cur_pol = policy_of(mode_q, run_q);
    tgt_w   = (mode_q == M_SHDN) ? 2'd0 : run_q;
  end

  always_comb begin
    mode_d = mode_q;
    run_d  = run_q;
    pend_d = pend_q;
    tgt_d  = tgt_q;
    rst_d  = 1'b0;
    if (pend_q) begin
      if (osc_ready) begin
        mode_d = run_mode(tgt_q);
        run_d  = tgt_q;
        pend_d = 1'b0;
      end
    end else if (!is_run(mode_q)) begin
      if (wake_ok) begin
        if (mode_q == M_SHDN) begin
          rst_d = 1'b1;
          run_d = 2'd0;
        end
        if (tgt_w != 2'd2 && !cur_pol.osc) begin
          pend_d = 1'b1;
          tgt_d  = tgt_w;
        end else begin
          mode_d = run_mode(tgt_w);
          run_d  = tgt_w;
        end
      end
    end else if (entry_req) begin
      case (entry_family)
        FAM_RUN: if (entry_sub != 2'd3) begin
          if (entry_sub != 2'd2 && run_q == 2'd2) begin
            pend_d = 1'b1;
            tgt_d  = entry_sub;
          end else begin
            mode_d = run_mode(entry_sub);
            run_d  = entry_sub;
          end
        end
        FAM_SLP:  mode_d = mode_t'(4'(M_SLP0) + {2'b00, run_q});
        FAM_STP:  if (entry_sub != 2'd3) mode_d = mode_t'(4'(M_STP0) + {2'b00, entry_sub});
        FAM_SBY:  if (!entry_sub[1]) mode_d = mode_t'(4'(M_SBY0) + {3'b000, entry_sub[0]});
        FAM_SHDN: mode_d = M_SHDN;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_RUN0;
      run_q  <= 2'd0;
      pend_q <= 1'b0;
      tgt_q  <= 2'd0;
      rst_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      pend_q <= pend_d;
      tgt_q  <= tgt_d;
      rst_q  <= rst_d;
    end
  end

  // R9
  rst_from_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> (mode_q == M_SHDN || $past(mode_q) == M_SHDN));

  // R11
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !osc_ready) |=> $stable(mode_q));

  // R8
  aon_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stb && !pend_q && !wake_irq_aon) |=> $stable(mode_q));

  // R10
  wake_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_run(mode_q) && mode_q != M_SHDN) |=> (!is_run(mode_q) || mode_q == run_mode($past(run_q))));

endmodule

// File: rtl/lpm_policy.sv
module lpm_policy
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            mode_d,
  input  logic [SUB_W-1:0] run_d,
  input  logic             pend_d,
  input  mode_t            mode_q,
  output pol_t             pol_q
);

  pol_t pol_d;

  always_comb begin
    pol_d = policy_of(mode_d, run_d);
    if (pend_d) pol_d.osc = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= policy_of(M_RUN0, 2'd0);
    else        pol_q <= pol_d;
  end

  // R3
  cpu_run_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pol_q.cpu |-> is_run(mode_q));

  // R7
  shdn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SHDN) |-> (pol_q.drive == DRV_OFF && pol_q.off && !pol_q.mclk));

  // R6
  stby_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SBY0 || mode_q == M_SBY1) |-> (!pol_q.mclk && pol_q.tim && pol_q.drive == DRV_LOW));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       entry_req,
  input  logic [2:0] entry_family,
  input  logic [1:0] entry_sub,
  input  logic       wake_irq_any,
  input  logic       wake_irq_aon,
  input  logic       wake_io,
  input  logic       osc_ready,
  output logic       osc_en,
  output logic       cpu_clk_en,
  output logic       main_clk_en,
  output logic       main_clk_fast,
  output logic       ulp_clk_en,
  output logic [1:0] ulp_clk_sel,
  output logic       timer_clk_en,
  output logic [1:0] vreg_drive,
  output logic       retain_off,
  output logic       sys_reset_out,
  output logic [3:0] mode_o,
  output logic       osc_busy
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;
  mode_t                  mode_d, mode_q;
  logic [SUB_W-1:0]       run_d;
  logic                   pend_d, pend_q, rst_q;
  pol_t                   pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  lpm_seq i_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .entry_req(entry_req), .entry_family(entry_family), .entry_sub(entry_sub),
    .wake_irq_any(wake_irq_any), .wake_irq_aon(wake_irq_aon), .wake_io(wake_io),
    .osc_ready(osc_ready),
    .mode_d(mode_d), .run_d(run_d), .pend_d(pend_d),
    .mode_q(mode_q), .pend_q(pend_q), .rst_q(rst_q)
  );

  lpm_policy i_policy (
    .clk(clk), .rst_n(rst_sync_n),
    .mode_d(mode_d), .run_d(run_d), .pend_d(pend_d),
    .mode_q(mode_q), .pol_q(pol_q)
  );

  assign osc_en        = pol_q.osc;
  assign cpu_clk_en    = pol_q.cpu;
  assign main_clk_en   = pol_q.mclk;
  assign main_clk_fast = pol_q.fast;
  assign ulp_clk_en    = pol_q.ulp_en;
  assign ulp_clk_sel   = pol_q.ulp_sel;
  assign timer_clk_en  = pol_q.tim;
  assign vreg_drive    = pol_q.drive;
  assign retain_off    = pol_q.off;
  assign sys_reset_out = rst_q;
  assign mode_o        = mode_q;
  assign osc_busy      = pend_q;

endmodule

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic entry_req = 1'b0;
  logic [2:0] entry_family = 3'd0;
  logic [1:0] entry_sub = 2'd0;
  logic wake_irq_any = 1'b0, wake_irq_aon = 1'b0, wake_io = 1'b0;
  logic osc_ready = 1'b1;
  logic osc_en, cpu_clk_en, main_clk_en, main_clk_fast, ulp_clk_en, timer_clk_en;
  logic retain_off, sys_reset_out, osc_busy;
  logic [1:0] ulp_clk_sel, vreg_drive;
  logic [3:0] mode_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl i_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .entry_family(entry_family),
    .entry_sub(entry_sub), .wake_irq_any(wake_irq_any), .wake_irq_aon(wake_irq_aon),
    .wake_io(wake_io), .osc_ready(osc_ready), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
    .main_clk_en(main_clk_en), .main_clk_fast(main_clk_fast), .ulp_clk_en(ulp_clk_en),
    .ulp_clk_sel(ulp_clk_sel), .timer_clk_en(timer_clk_en), .vreg_drive(vreg_drive),
    .retain_off(retain_off), .sys_reset_out(sys_reset_out), .mode_o(mode_o),
    .osc_busy(osc_busy)
  );

  // Expected policy {osc,cpu,mclk,fast,ulp_en,ulp_sel[1:0],tim,drive[1:0],off}
  localparam logic [10:0] P_RUN0  = 11'b1_1_1_1_1_10_1_11_0;
  localparam logic [10:0] P_RUN1  = 11'b1_1_1_0_1_00_1_11_0;
  localparam logic [10:0] P_RUN2  = 11'b0_1_1_0_1_00_1_11_0;
  localparam logic [10:0] P_SLP0  = 11'b1_0_1_1_1_10_1_11_0;
  localparam logic [10:0] P_SLP1  = 11'b1_0_1_0_1_00_1_11_0;
  localparam logic [10:0] P_SLP2  = 11'b0_0_1_0_1_00_1_11_0;
  localparam logic [10:0] P_STP0A = 11'b1_0_0_0_1_01_1_10_0;
  localparam logic [10:0] P_STP0B = 11'b1_0_0_0_1_00_1_10_0;
  localparam logic [10:0] P_STP0C = 11'b0_0_0_0_1_00_1_10_0;
  localparam logic [10:0] P_STP1  = 11'b1_0_0_0_1_01_1_10_0;
  localparam logic [10:0] P_STP2  = 11'b0_0_0_0_1_00_1_10_0;
  localparam logic [10:0] P_SBY0  = 11'b0_0_0_0_1_00_1_01_0;
  localparam logic [10:0] P_SBY1  = 11'b0_0_0_0_0_00_1_01_0;
  localparam logic [10:0] P_SHDN  = 11'b0_0_0_0_0_00_0_00_1;

  localparam logic [1:0] A_ENT = 2'd0, A_ANY = 2'd1, A_AON = 2'd2, A_IO = 2'd3;

  // {action, family, sub, expected mode, expected policy}
  localparam int NV = 32;
  localparam logic [21:0] VEC [NV] = '{
    {A_ENT, 3'd0, 2'd1, 4'd1,  P_RUN1},   // R2
    {A_ENT, 3'd1, 2'd0, 4'd4,  P_SLP1},   // R3
    {A_AON, 3'd0, 2'd0, 4'd1,  P_RUN1},   // R8 R10
    {A_ENT, 3'd2, 2'd0, 4'd6,  P_STP0B},  // R4 from RUN1
    {A_ANY, 3'd0, 2'd0, 4'd6,  P_STP0B},  // R8 ignored
    {A_AON, 3'd0, 2'd0, 4'd1,  P_RUN1},   // R10
    {A_ENT, 3'd0, 2'd2, 4'd2,  P_RUN2},   // R2
    {A_ENT, 3'd2, 2'd0, 4'd6,  P_STP0C},  // R4 from RUN2
    {A_AON, 3'd0, 2'd0, 4'd2,  P_RUN2},   // R10
    {A_ENT, 3'd0, 2'd0, 4'd0,  P_RUN0},   // R10 handshake
    {A_ENT, 3'd2, 2'd0, 4'd6,  P_STP0A},  // R4 from RUN0
    {A_AON, 3'd0, 2'd0, 4'd0,  P_RUN0},
    {A_ENT, 3'd2, 2'd2, 4'd8,  P_STP2},   // R5
    {A_AON, 3'd0, 2'd0, 4'd0,  P_RUN0},   // R10
    {A_ENT, 3'd2, 2'd1, 4'd7,  P_STP1},   // R5
    {A_IO,  3'd0, 2'd0, 4'd7,  P_STP1},   // R8 ignored
    {A_AON, 3'd0, 2'd0, 4'd0,  P_RUN0},
    {A_ENT, 3'd3, 2'd1, 4'd10, P_SBY1},   // R6
    {A_AON, 3'd0, 2'd0, 4'd0,  P_RUN0},
    {A_ENT, 3'd3, 2'd0, 4'd9,  P_SBY0},   // R6 R7
    {A_ANY, 3'd0, 2'd0, 4'd9,  P_SBY0},   // R8 ignored
    {A_AON, 3'd0, 2'd0, 4'd0,  P_RUN0},
    {A_ENT, 3'd1, 2'd2, 4'd3,  P_SLP0},   // R3 sub ignored
    {A_ANY, 3'd0, 2'd0, 4'd0,  P_RUN0},   // R8
    {A_ENT, 3'd0, 2'd2, 4'd2,  P_RUN2},
    {A_ENT, 3'd1, 2'd0, 4'd5,  P_SLP2},   // R3
    {A_ANY, 3'd0, 2'd0, 4'd2,  P_RUN2},   // R10
    {A_ENT, 3'd4, 2'd0, 4'd11, P_SHDN},   // R7
    {A_AON, 3'd0, 2'd0, 4'd11, P_SHDN},   // R8 ignored
    {A_ENT, 3'd0, 2'd0, 4'd11, P_SHDN},   // R11 entry in low power
    {A_IO,  3'd0, 2'd0, 4'd0,  P_RUN0},   // R9
    {A_ENT, 3'd3, 2'd2, 4'd0,  P_RUN0}    // R11 bad sub
  };

  function automatic logic [10:0] act_pol();
    return {osc_en, cpu_clk_en, main_clk_en, main_clk_fast, ulp_clk_en,
            ulp_clk_sel, timer_clk_en, vreg_drive, retain_off};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] a, input logic [2:0] f, input logic [1:0] s);
    @(negedge clk);
    entry_family = f;
    entry_sub    = s;
    entry_req    = (a == A_ENT);
    wake_irq_any = (a == A_ANY);
    wake_irq_aon = (a == A_AON);
    wake_io      = (a == A_IO);
    @(negedge clk);
    entry_req = 1'b0; wake_irq_any = 1'b0; wake_irq_aon = 1'b0; wake_io = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", 32'(mode_o), 32'd0);
    chk("R1 policy", 32'(act_pol()), 32'(P_RUN0));
    chk("R1 busy/rst", {30'd0, osc_busy, sys_reset_out}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][21:20], VEC[i][19:17], VEC[i][16:15]);
      @(negedge clk);
      chk($sformatf("R2-table step %0d mode", i), 32'(mode_o), 32'(VEC[i][14:11]));
      chk($sformatf("R7 table step %0d policy", i), 32'(act_pol()), 32'(VEC[i][10:0]));
    end

    // R10 R11: wake from STOP2 back to RUN0 with a slow oscillator
    apply(A_ENT, 3'd2, 2'd2);
    osc_ready = 1'b0;
    apply(A_AON, 3'd0, 2'd0);
    chk("R10 hold mode", 32'(mode_o), 32'd8);
    chk("R10 osc forced", {30'd0, osc_en, osc_busy}, 32'd3);
    apply(A_ENT, 3'd4, 2'd0);
    chk("R11 entry while busy", 32'(mode_o), 32'd8);
    osc_ready = 1'b1;
    @(negedge clk);
    chk("R10 resume RUN0", 32'(mode_o), 32'd0);
    chk("R10 busy clear", 32'(osc_busy), 32'd0);

    // R10 RUN request from RUN2 waits for oscillator
    apply(A_ENT, 3'd0, 2'd2);
    osc_ready = 1'b0;
    apply(A_ENT, 3'd0, 2'd1);
    @(negedge clk);
    chk("R10 run req hold", 32'(mode_o), 32'd2);
    chk("R10 run req osc", 32'(osc_en), 32'd1);
    osc_ready = 1'b1;
    @(negedge clk);
    chk("R10 run req done", 32'(mode_o), 32'd1);
    chk("R2 RUN1 policy", 32'(act_pol()), 32'(P_RUN1));

    // R11 unsupported STOP sub
    apply(A_ENT, 3'd2, 2'd3);
    chk("R11 stop sub3", 32'(mode_o), 32'd1);

    // R9 shutdown wake pulse
    apply(A_ENT, 3'd4, 2'd0);
    @(negedge clk);
    wake_io = 1'b1;
    @(negedge clk);
    wake_io = 1'b0;
    chk("R9 reset pulse high", 32'(sys_reset_out), 32'd1);
    @(negedge clk);
    chk("R9 reset pulse low", 32'(sys_reset_out), 32'd0);
    chk("R9 restart RUN0", 32'(mode_o), 32'd0);
    chk("R9 run sub cleared", 32'(act_pol()), 32'(P_RUN0));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule